// File: doc/BRIEF.md
# Sticky Status Alert Controller

This block watches sixteen out-of-limit condition inputs. Each input has a status bit that latches when the condition appears. The bit stays latched after the condition goes away, so a short excursion between two software polls is never missed. Software reads the status bits through two 8-bit registers. A read clears a bit only if its condition is no longer active. A condition that is still present simply stays visible.

Each source also has a mask bit, held in two read/write 8-bit registers. The block combines the unmasked status bits into one active-low alert line. An interrupt handler can silence a source that stays out of limit by setting its mask bit. It can keep polling the still-updating status bits, and it clears the mask to re-arm the source once the status has gone away. The register port is a plain parallel interface: an address, a one-cycle read strobe with combinational read data, and a write strobe with write data.

Top module: `alert_status_ctrl`

## Requirements
- R1: A condition input sampled high at a clock edge sets its status bit at that edge. Input bits 0..7 map to bits 0..7 of the low status register, and input bits 8..15 map to bits 0..7 of the high status register.
- R2: A set status bit stays at 1 after its condition returns low, until a read of its status register.
- R3: A read of a status register clears, at the closing edge of the read cycle, exactly those bits of that register whose condition is low in that cycle. If a condition is high in the cycle of the read, its bit stays set, because set wins over clear. A read of one status register leaves the other one unchanged.
- R4: During a read strobe, reg_rdata shows the selected register as it was before the read. The low status register is at address 0x41 and the high one at 0x42.
- R5: alert_n is active low. It is 0 in the cycle after any status bit whose mask bit is 0 is set. It returns to 1 in the cycle after no such bit remains.
- R6: A mask bit at 1 keeps its source from driving alert_n low. The masked source still sets and holds its status bit, and that bit can still be read.
- R7: The mask registers are read/write at 0x72 (sources 0..7) and 0x73 (sources 8..15), with bit n of a register covering source n of its byte. After a mask bit is written back to 0, a set status bit of that source drives alert_n low again.
- R8: Writes to the status addresses have no effect. A read of any address other than the four mapped ones returns 0x00.
- R9: While rst_n is low, all status bits and mask bits are cleared and alert_n is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | 16 | Out-of-limit condition per source, active high |
| reg_addr | input | ADDR_W | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| alert_n | output | 1 | Registered alert, active low |

## Verification
The bench builds the block with its default parameters: an 8-bit address and the register addresses 0x41, 0x42, 0x72 and 0x73. With these values, every mapped address can be exercised, along with one unmapped address and writes aimed at the read-only status registers. The stimulus covers several situations: a one-cycle condition pulse, a condition still held across reads, a read in the same cycle as a new pulse, reads that touch only one byte, and a mask that is set and then cleared on a source that stays active.

// File: rtl/alert_status_ctrl.sv
module alert_status_ctrl #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ST_LO_ADDR = 8'h41,
  parameter logic [ADDR_W-1:0] ST_HI_ADDR = 8'h42,
  parameter logic [ADDR_W-1:0] MK_LO_ADDR = 8'h72,
  parameter logic [ADDR_W-1:0] MK_HI_ADDR = 8'h73
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cond_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              alert_n
);

  logic [15:0] status_q, mask_q, rd_clr;
  logic        alert_q;

  wire hit_sl = reg_addr == ST_LO_ADDR;
  wire hit_sh = reg_addr == ST_HI_ADDR;
  wire hit_ml = reg_addr == MK_LO_ADDR;
  wire hit_mh = reg_addr == MK_HI_ADDR;

  assign rd_clr  = {{8{reg_rd & hit_sh}}, {8{reg_rd & hit_sl}}};
  assign alert_n = alert_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      alert_q  <= 1'b1;
    end else begin
      status_q <= cond_i | (status_q & ~rd_clr);
      if (reg_wr && hit_ml) mask_q[7:0]  <= reg_wdata;
      if (reg_wr && hit_mh) mask_q[15:8] <= reg_wdata;
      alert_q  <= ~|(status_q & ~mask_q);
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_rd) begin
      if (hit_sl)      reg_rdata = status_q[7:0];
      else if (hit_sh) reg_rdata = status_q[15:8];
      else if (hit_ml) reg_rdata = mask_q[7:0];
      else if (hit_mh) reg_rdata = mask_q[15:8];
    end
  end

  // Set on condition
  assert_cond_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(cond_i)) == $past(cond_i)));

  // Bits rise only from a condition, never from a write
  assert_rise_from_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(cond_i)) == 16'h0));

  // Bits fall only through a read of their byte with the condition gone
  assert_clear_only_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~status_q & ~($past(rd_clr) & ~$past(cond_i))) == 16'h0));

  // Alert low only for an unmasked pending source
  assert_alert_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (alert_n || ($past(status_q & ~mask_q) != 16'h0)));

  // Masked-only pending sources leave the alert high
  assert_mask_silences_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q != 16'h0) && ((status_q & ~mask_q) == 16'h0)) |=> alert_n);

  always_comb
    if (rst_n && reg_rd && !(hit_sl || hit_sh || hit_ml || hit_mh))
      assert_unmapped_zero_R8: assert (reg_rdata == 8'h00);

endmodule

// File: tb/alert_status_ctrl_test.sv
module alert_status_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cond_i = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        alert_n;

  int checks = 0;
  int errors = 0;
  bit running = 0;
  string alert_tag = "R9";

  logic [15:0] m_status = '0, m_mask = '0;
  logic        m_alert_n = 1'b1;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  alert_status_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model_read(input logic [7:0] a);
    case (a)
      8'h41: return m_status[7:0];
      8'h42: return m_status[15:8];
      8'h72: return m_mask[7:0];
      8'h73: return m_mask[15:8];
      default: return 8'h00;
    endcase
  endfunction

  // Monitor: samples at the falling edge, pops the scoreboard on reads
  always @(negedge clk) if (running) begin
    checks++;
    if (alert_n !== m_alert_n) begin
      errors++;
      $display("FAIL %s alert_n actual %b expected %b", alert_tag, alert_n, m_alert_n);
    end
    if (reg_rd) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s read @%h actual %h expected %h", t, reg_addr, reg_rdata, e);
      end
    end
  end

  // Driver: one cycle of stimulus, entered at posedge+1
  task automatic cyc(input logic [15:0] c, input logic rd, input logic wr,
                     input logic [7:0] a, input logic [7:0] d, input string t);
    logic [15:0] clr;
    cond_i = c; reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    if (rd) begin exp_q.push_back(model_read(a)); tag_q.push_back(t); end
    @(posedge clk); #1;
    clr = '0;
    if (rd && a == 8'h41) clr[7:0]  = 8'hFF;
    if (rd && a == 8'h42) clr[15:8] = 8'hFF;
    m_alert_n = ~|(m_status & ~m_mask);
    m_status  = c | (m_status & ~clr);
    if (wr && a == 8'h72) m_mask[7:0]  = d;
    if (wr && a == 8'h73) m_mask[15:8] = d;
    reg_rd = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] c, input logic [7:0] a, input string t);
    cyc(c, 1'b1, 1'b0, a, 8'h00, t);
  endtask

  task automatic idle(input logic [15:0] c, input int n);
    for (int i = 0; i < n; i++) cyc(c, 1'b0, 1'b0, 8'h00, 8'h00, "");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; running = 1;
    // R9 reset state
    rd(16'h0, 8'h41, "R9"); rd(16'h0, 8'h42, "R9");
    rd(16'h0, 8'h72, "R9"); rd(16'h0, 8'h73, "R9");
    // R1 R2 pulse latched and held; R5 alert follows
    alert_tag = "R5";
    cyc(16'h0008, 0, 0, 0, 0, "");
    idle(16'h0, 4);
    rd(16'h0, 8'h41, "R2");   // 0x08
    rd(16'h0, 8'h41, "R3");   // cleared -> 0x00
    idle(16'h0, 2);
    // R3 active condition survives reads
    cyc(16'h0200, 0, 0, 0, 0, "");
    rd(16'h0200, 8'h42, "R1");
    rd(16'h0200, 8'h42, "R3");
    rd(16'h0000, 8'h42, "R3");
    rd(16'h0000, 8'h42, "R3");
    // R3 set wins over clear in same cycle
    rd(16'h0001, 8'h41, "R3");
    rd(16'h0000, 8'h41, "R3");
    rd(16'h0000, 8'h41, "R3");
    // R3 R4 a read touches only its own byte
    cyc(16'h1002, 0, 0, 0, 0, "");
    rd(16'h0, 8'h41, "R4");
    rd(16'h0, 8'h41, "R3");
    rd(16'h0, 8'h42, "R4");
    rd(16'h0, 8'h42, "R3");
    idle(16'h0, 2);
    // R6 masked source still latches
    alert_tag = "R6";
    cyc(16'h0, 0, 1, 8'h73, 8'h80, "");
    rd(16'h0, 8'h73, "R7");
    idle(16'h8000, 4);
    rd(16'h8000, 8'h42, "R6");
    // R7 unmask re-enables alert
    alert_tag = "R7";
    cyc(16'h8000, 0, 1, 8'h73, 8'h00, "");
    idle(16'h8000, 3);
    cyc(16'h0, 0, 1, 8'h72, 8'h5A, "");
    rd(16'h0, 8'h72, "R7");
    rd(16'h0, 8'h42, "R7");
    rd(16'h0, 8'h42, "R7");
    idle(16'h0, 2);
    // R8 status writes ignored, unmapped reads zero
    alert_tag = "R8";
    cyc(16'h0, 0, 1, 8'h41, 8'hFF, "");
    cyc(16'h0, 0, 1, 8'h42, 8'hFF, "");
    idle(16'h0, 2);
    rd(16'h0, 8'h41, "R8");
    rd(16'h0, 8'h42, "R8");
    rd(16'h0, 8'h55, "R8");
    rd(16'h0, 8'h00, "R8");
    running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule